// File: doc/BRIEF.md
# Tick-Aligned Event Deferral Queue

This block sits between asynchronous event sources and a core that runs on a fixed schedule of logical ticks. Events never reach the core when they arrive. Each accepted event is stamped with the value of the global time counter and with the index of the tick it arrived in. It is then held in a FIFO.

When the tick pulse closes a tick, every event that arrived during that tick becomes eligible. The core drains the closed batches in arrival order through a valid/ready stream. A flag marks the final record of each batch, and a count register reports how many events the closed tick held. A burst of events only fills the FIFO; the core's schedule is untouched. When the FIFO is full, further events are discarded and counted in a saturating drop counter.

Top module: `tick_defer_queue`

## Requirements
- R1: After reset, `rec_valid_o` is 0, `batch_cnt_o` is 0 and `drop_cnt_o` is 0. The tick index starts at 0 and increases by one on each cycle in which `tick_i` is high.
- R2: An accepted event's record carries the `ev_id_i` value and the `gtime_i` value sampled on the clock edge where `ev_valid_i` was high.
- R3: A record never appears on the output while its tick is still open. Once the closing `tick_i` edge has passed, the record is presented on the next cycle unless older records are still waiting.
- R4: An event sampled on the same edge as `tick_i` belongs to the new tick. It is released only at the following tick pulse, and its `rec_tick_o` is the incremented index.
- R5: Records leave in the order their events were accepted.
- R6: `rec_last_o` is 1 on the final accepted record of each tick's batch and 0 on every other record.
- R7: On each `tick_i` edge, `batch_cnt_o` takes the number of events accepted during the tick being closed. It is 0 for an empty tick and does not change between tick pulses.
- R8: An event that arrives while the FIFO holds DEPTH records is discarded and increments `drop_cnt_o`. The drop counter saturates at its all-ones value, and dropped events produce no record.
- R9: While `rec_valid_o` is 1 and `rec_ready_i` is 0, the valid signal and all record fields hold steady. A record is consumed on an edge where both are 1.
- R10: `rec_tick_o` equals the index of the tick in which the event was accepted, counted as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event strobe, one event per cycle |
| ev_id_i | input | ID_W | Event identifier |
| gtime_i | input | TIME_W | Global time counter |
| tick_i | input | 1 | Logical tick boundary pulse |
| rec_valid_o | output | 1 | Record from a closed tick available |
| rec_ready_i | input | 1 | Core accepts the record |
| rec_id_o | output | ID_W | Record event identifier |
| rec_time_o | output | TIME_W | Record arrival timestamp |
| rec_tick_o | output | TICK_W | Record arrival tick index |
| rec_last_o | output | 1 | Final record of its tick batch |
| batch_cnt_o | output | CNT_W | Events accepted in the last closed tick |
| drop_cnt_o | output | DROP_W | Saturating count of discarded events |

## Verification
The bench targets events that coincide with the tick pulse. A design that stamped such an event with the old tick would release it one tick early and carry the wrong tick index. Empty ticks are exercised because a design that marks a "last" record without checking the batch size would flag a record of an earlier batch. The bench also tests a design that reports a stale count. It overfills the FIFO with the consumer stalled, so a design that overwrites stored records or lets the drop counter wrap shows corrupted records or a small count. Random back-pressure mixed with ticks and events checks the ordering, the stalled-output hold and the rule that no record leaks out of an open tick.

// File: rtl/tick_defer_pkg.sv
package tick_defer_pkg;
  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/tick_defer_store.sv
module tick_defer_store #(
  parameter int ID_W   = 8,
  parameter int TIME_W = 32,
  parameter int TICK_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = tick_defer_pkg::ptr_width(DEPTH),
  localparam int CNT_W = tick_defer_pkg::cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [TIME_W-1:0] push_time_i,
  input  logic [TICK_W-1:0] push_tick_i,
  input  logic              pop_i,
  input  logic              mark_last_i,
  output logic              full_o,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [TIME_W-1:0] rd_time_o,
  output logic [TICK_W-1:0] rd_tick_o,
  output logic              rd_last_o
);
  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [TIME_W-1:0] time_mem [DEPTH];
  logic [TICK_W-1:0] tick_mem [DEPTH];
  logic [DEPTH-1:0]  last_mem;
  logic [PTR_W-1:0]  wr_idx, rd_idx, last_idx;
  logic [CNT_W-1:0]  occ;

  function automatic logic [PTR_W-1:0] idx_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (occ == CNT_W'(DEPTH));
  assign rd_id_o   = id_mem[rd_idx];
  assign rd_time_o = time_mem[rd_idx];
  assign rd_tick_o = tick_mem[rd_idx];
  assign rd_last_o = last_mem[rd_idx];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      id_mem[wr_idx]   <= push_id_i;
      time_mem[wr_idx] <= push_time_i;
      tick_mem[wr_idx] <= push_tick_i;
    end
  end

  // mark targets the newest record of the closing tick; it is never the slot written now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_mem <= '0;
    end else begin
      if (push_i)      last_mem[wr_idx]   <= 1'b0;
      if (mark_last_i) last_mem[last_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      last_idx <= '0;
      occ      <= '0;
    end else begin
      if (push_i) begin
        wr_idx   <= idx_inc(wr_idx);
        last_idx <= wr_idx;
      end
      if (pop_i) rd_idx <= idx_inc(rd_idx);
      case ({push_i, pop_i})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/tick_defer_ctl.sv
module tick_defer_ctl #(
  parameter int TICK_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = tick_defer_pkg::cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [TICK_W-1:0] stamp_tick_o,
  output logic              mark_last_o,
  output logic              rel_avail_o,
  output logic [CNT_W-1:0]  batch_cnt_o
);
  logic [TICK_W-1:0] cur_tick;
  logic [CNT_W-1:0]  cur_cnt;  // accepted in the open tick
  logic [CNT_W-1:0]  rel_cnt;  // stored records of closed ticks

  assign stamp_tick_o = tick_i ? cur_tick + 1'b1 : cur_tick;
  assign mark_last_o  = tick_i && (cur_cnt != '0);
  assign rel_avail_o  = (rel_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_tick    <= '0;
      cur_cnt     <= '0;
      rel_cnt     <= '0;
      batch_cnt_o <= '0;
    end else if (tick_i) begin
      cur_tick    <= cur_tick + 1'b1;
      batch_cnt_o <= cur_cnt;
      cur_cnt     <= CNT_W'(push_i);
      rel_cnt     <= rel_cnt + cur_cnt - CNT_W'(pop_i);
    end else begin
      cur_cnt <= cur_cnt + CNT_W'(push_i);
      rel_cnt <= rel_cnt - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/tick_defer_satcnt.sv
module tick_defer_satcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tick_defer_queue.sv
module tick_defer_queue #(
  parameter int ID_W   = 8,
  parameter int TIME_W = 32,
  parameter int TICK_W = 16,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8,
  localparam int CNT_W = tick_defer_pkg::cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [ID_W-1:0]   ev_id_i,
  input  logic [TIME_W-1:0] gtime_i,
  input  logic              tick_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [ID_W-1:0]   rec_id_o,
  output logic [TIME_W-1:0] rec_time_o,
  output logic [TICK_W-1:0] rec_tick_o,
  output logic              rec_last_o,
  output logic [CNT_W-1:0]  batch_cnt_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              full, push, pop, mark_last, rel_avail;
  logic [TICK_W-1:0] stamp_tick;

  assign push        = ev_valid_i && !full;
  assign rec_valid_o = rel_avail;
  assign pop         = rel_avail && rec_ready_i;

  tick_defer_store #(
    .ID_W(ID_W), .TIME_W(TIME_W), .TICK_W(TICK_W), .DEPTH(DEPTH)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_id_i   (ev_id_i),
    .push_time_i (gtime_i),
    .push_tick_i (stamp_tick),
    .pop_i       (pop),
    .mark_last_i (mark_last),
    .full_o      (full),
    .rd_id_o     (rec_id_o),
    .rd_time_o   (rec_time_o),
    .rd_tick_o   (rec_tick_o),
    .rd_last_o   (rec_last_o)
  );

  tick_defer_ctl #(
    .TICK_W(TICK_W), .DEPTH(DEPTH)
  ) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .push_i       (push),
    .pop_i        (pop),
    .stamp_tick_o (stamp_tick),
    .mark_last_o  (mark_last),
    .rel_avail_o  (rel_avail),
    .batch_cnt_o  (batch_cnt_o)
  );

  tick_defer_satcnt #(
    .W(DROP_W)
  ) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ev_valid_i && full),
    .cnt_o  (drop_cnt_o)
  );
endmodule

// File: rtl/tick_defer_chk.sv
module tick_defer_chk #(
  parameter int ID_W   = 8,
  parameter int TIME_W = 32,
  parameter int TICK_W = 16,
  parameter int DROP_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic              tick_i,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [ID_W-1:0]   rec_id_o,
  input logic [TIME_W-1:0] rec_time_o,
  input logic [TICK_W-1:0] rec_tick_o,
  input logic              rec_last_o,
  input logic [CNT_W-1:0]  batch_cnt_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_id_o) &&
      $stable(rec_time_o) && $stable(rec_tick_o) && $stable(rec_last_o));

  assert_release_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_valid_o) |-> $past(tick_i));

  assert_batch_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(batch_cnt_o) |-> $past(tick_i));

  assert_drop_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |->
      (drop_cnt_o == DROP_W'($past(drop_cnt_o) + 1'b1)) && $past(ev_valid_i));

  assert_drop_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&drop_cnt_o) |=> (&drop_cnt_o));
endmodule

bind tick_defer_queue tick_defer_chk #(
  .ID_W(ID_W), .TIME_W(TIME_W), .TICK_W(TICK_W), .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_valid_i  (ev_valid_i),
  .tick_i      (tick_i),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_id_o    (rec_id_o),
  .rec_time_o  (rec_time_o),
  .rec_tick_o  (rec_tick_o),
  .rec_last_o  (rec_last_o),
  .batch_cnt_o (batch_cnt_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/tick_defer_queue_test.sv
module tick_defer_queue_test;
  localparam int ID_W = 8, TIME_W = 16, TICK_W = 8, DEPTH = 4, DROP_W = 2;
  localparam int CNT_W = tick_defer_pkg::cnt_width(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid_i = 1'b0, tick_i = 1'b0, rec_ready_i = 1'b0;
  logic [ID_W-1:0] ev_id_i = '0;
  logic [TIME_W-1:0] gtime_i = 16'h1000;
  logic rec_valid_o, rec_last_o;
  logic [ID_W-1:0] rec_id_o;
  logic [TIME_W-1:0] rec_time_o;
  logic [TICK_W-1:0] rec_tick_o;
  logic [CNT_W-1:0] batch_cnt_o;
  logic [DROP_W-1:0] drop_cnt_o;

  always #4 clk = ~clk;  // 125 MHz

  tick_defer_queue #(.ID_W(ID_W), .TIME_W(TIME_W), .TICK_W(TICK_W),
                     .DEPTH(DEPTH), .DROP_W(DROP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid_i), .ev_id_i(ev_id_i),
    .gtime_i(gtime_i), .tick_i(tick_i), .rec_valid_o(rec_valid_o),
    .rec_ready_i(rec_ready_i), .rec_id_o(rec_id_o), .rec_time_o(rec_time_o),
    .rec_tick_o(rec_tick_o), .rec_last_o(rec_last_o),
    .batch_cnt_o(batch_cnt_o), .drop_cnt_o(drop_cnt_o));

  typedef struct {
    logic [ID_W-1:0]   id;
    logic [TIME_W-1:0] ts;
    logic [TICK_W-1:0] tk;
    bit                last;
  } rec_t;

  rec_t exp_q[$];
  int checks = 0, fails = 0, n_recv = 0;
  int m_cnt = 0, exp_batch = 0, m_drop = 0;
  logic [TICK_W-1:0] m_tick = '0;
  bit chk_batch = 0, done = 0;
  int rdy_mode = 1;  // 0 always ready, 1 stalled, 2 random
  logic [15:0] lfsr = 16'hace1;

  always @(posedge clk) begin
    gtime_i <= gtime_i + 16'd3;
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rec_ready_i <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lfsr[3];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock cycle of stimulus; model updated right after the sampling edge
  task automatic step(input bit ev, input logic [ID_W-1:0] id, input bit tk);
    logic [TIME_W-1:0] ts;
    bit acc;
    @(negedge clk);
    ev_valid_i = ev; ev_id_i = id; tick_i = tk;
    ts  = gtime_i;
    acc = ev && (exp_q.size() < DEPTH);
    @(posedge clk);
    if (tk) begin
      if (m_cnt > 0) exp_q[exp_q.size()-1].last = 1;
      exp_batch = m_cnt;
      m_cnt = 0;
      m_tick++;
      chk_batch = 1;
    end
    if (acc) begin
      exp_q.push_back('{id: id, ts: ts, tk: m_tick, last: 0});
      m_cnt++;
    end else if (ev && m_drop < 3) m_drop++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (chk_batch) begin
        chk(batch_cnt_o == CNT_W'(exp_batch), "R7", "batch count",
            batch_cnt_o, exp_batch);
        chk_batch = 0;
      end
      if (rec_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3", "record with nothing closed", rec_id_o, -1);
        end else begin
          chk(exp_q[0].tk != m_tick, "R3", "record of open tick", rec_tick_o, m_tick);
          chk(rec_id_o == exp_q[0].id, "R5", "id order", rec_id_o, exp_q[0].id);
          chk(rec_time_o == exp_q[0].ts, "R2", "timestamp", rec_time_o, exp_q[0].ts);
          chk(rec_tick_o == exp_q[0].tk, "R10", "tick index", rec_tick_o, exp_q[0].tk);
          chk(rec_last_o == exp_q[0].last, "R6", "last flag", rec_last_o, exp_q[0].last);
          if (rec_ready_i) begin
            void'(exp_q.pop_front());
            n_recv++;
          end  // else R9: same front is compared again next cycle
        end
      end else if (exp_q.size() > 0 && exp_q[0].tk != m_tick) begin
        chk(0, "R3", "closed record not presented", 0, 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rec_valid_o == 0, "R1", "valid in reset", rec_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rec_valid_o == 0, "R1", "valid after reset", rec_valid_o, 0);
    chk(batch_cnt_o == 0, "R1", "batch after reset", batch_cnt_o, 0);
    chk(drop_cnt_o == 0, "R1", "drop after reset", drop_cnt_o, 0);

    // single event in tick 0, held until the tick closes (R3, R10)
    rdy_mode = 0;
    step(1, 8'h11, 0);
    idle(4);
    step(0, '0, 1);
    idle(3);
    chk(n_recv == 1, "R3", "single record delivered", n_recv, 1);

    // burst with random back-pressure, plus event on the tick edge (R4, R6, R9)
    rdy_mode = 2;
    step(1, 8'h21, 0);
    step(1, 8'h22, 0);
    step(1, 8'h23, 1);  // belongs to the new tick
    step(1, 8'h24, 0);
    idle(3);
    step(0, '0, 1);
    idle(10);
    // empty tick: count 0, no last marking (R7)
    step(0, '0, 1);
    idle(10);
    rdy_mode = 0;
    idle(4);
    chk(exp_q.size() == 0, "R4", "queue drained", exp_q.size(), 0);

    // overflow with stalled consumer (R8)
    rdy_mode = 1;
    idle(3);
    for (int i = 0; i < 6; i++) step(1, ID_W'(8'h40 + i), 0);
    @(negedge clk);
    chk(drop_cnt_o == DROP_W'(m_drop), "R8", "drops after fill", drop_cnt_o, m_drop);
    step(0, '0, 1);
    for (int i = 0; i < 3; i++) step(1, ID_W'(8'h50 + i), 0);
    @(negedge clk);
    chk(drop_cnt_o == 2'd3, "R8", "drop saturation", drop_cnt_o, 3);
    idle(4);
    chk(rec_id_o == 8'h40 && rec_valid_o, "R8", "oldest record intact", rec_id_o, 8'h40);
    rdy_mode = 0;
    idle(8);

    // random mixed traffic
    rdy_mode = 2;
    for (int i = 0; i < 600; i++) begin
      bit ev;
      ev = lfsr[0] && lfsr[5] && (exp_q.size() < DEPTH - 1);
      step(ev, ID_W'(i), (i % 7) == 6);
    end
    rdy_mode = 0;
    step(0, '0, 1);
    idle(12);
    chk(exp_q.size() == 0, "R5", "all records delivered", exp_q.size(), 0);
    chk(drop_cnt_o == 2'd3, "R8", "drop held", drop_cnt_o, 3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule